// File: doc/BRIEF.md
# In-Order Multi-Issue Window with Register Scoreboard

This block sits between decode and execute in a small superscalar front end. It holds up to `WIDTH` decoded instructions, each reduced to two source register indices and one destination index. Every cycle it walks the held instructions from oldest to youngest and issues the longest run that is free of data hazards. It stops at the first instruction that is not ready, so issue order always matches program order.

Hazards are found in two places. The first is a scoreboard with one availability bit per architectural register: issuing an instruction marks its destination unavailable, and a result writeback marks it available again. The second is a comparison against older instructions still in the window. A configuration input selects how the window refills. In aligned mode a new group is taken only once the whole current group has issued. In gliding mode, slots that empty in one cycle are filled from the fetch stream in the same cycle, so new instructions are examined in the next cycle.

Top module: `issue_window`

## Requirements
- R1: After reset the window is empty and every register is available: no issue lane is valid and, in either mode, every fetch lane shows ready.
- R2: An instruction issues only if the scoreboard bits of both of its sources are set. A writeback sets its bit at the clock edge, so the write becomes visible to the issue check one cycle after the writeback.
- R3: Issue is strictly in order. The instructions issued in a cycle are the oldest slots up to, but not including, the first one that cannot issue. Younger independent instructions behind it wait.
- R4: An instruction cannot issue in a cycle in which any older instruction still in the window has a destination equal to one of its sources.
- R5: Issuing clears the destination's scoreboard bit at the clock edge. A writeback sets the bit. When both target the same register in one cycle, the register ends up unavailable.
- R6: In aligned mode (`glide_i`=0), all fetch lanes are ready when the window is empty and none is ready otherwise.
- R7: In gliding mode (`glide_i`=1), fetch lane k is ready when k is less than `WIDTH` minus the number of instructions left after this cycle's issue.
- R8: Issue lane k carries the k-th oldest instruction issued this cycle. The valid bits are contiguous from lane 0, and each lane carries that instruction's source and destination indices.
- R9: The block accepts the fetch lanes 0..n-1 that form the leading run of lanes with both valid and ready set. They enter the window in lane order, younger than everything already in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glide_i | input | 1 | 1 selects gliding refill, 0 selects aligned refill |
| fetch_valid_i | input | WIDTH | Per-lane valid of offered instructions |
| fetch_src1_i | input | WIDTH*RIDX_W | First source index per lane |
| fetch_src2_i | input | WIDTH*RIDX_W | Second source index per lane |
| fetch_dst_i | input | WIDTH*RIDX_W | Destination index per lane |
| fetch_ready_o | output | WIDTH | Per-lane ready |
| wb_valid_i | input | NUM_WB | Writeback strobe per port |
| wb_reg_i | input | NUM_WB*RIDX_W | Register written back per port |
| issue_valid_o | output | WIDTH | Per-lane issue strobe |
| issue_src1_o | output | WIDTH*RIDX_W | First source of issued instruction |
| issue_src2_o | output | WIDTH*RIDX_W | Second source of issued instruction |
| issue_dst_o | output | WIDTH*RIDX_W | Destination of issued instruction |

## Verification
The bench first drives a group in which slot 1 reads the register that slot 0 writes and slot 2 is independent. A design that skips the window comparison would issue slot 1 alongside slot 0, and one that does not stop at the first blocked instruction would issue slot 2 early. It then issues a write to a register in the same cycle that a writeback to that register arrives, and checks that a later reader stays blocked; a design that let the set win would release the reader too soon. A long random phase keeps the register set small so that hazards are frequent. It switches between the two modes, and it checks the ready pattern every cycle, so that an aligned window that refills early, or a gliding window that miscounts its free slots, shows up.

// File: rtl/issue_pkg.sv
package issue_pkg;
  typedef enum logic {
    REFILL_ALIGNED = 1'b0,
    REFILL_GLIDE   = 1'b1
  } refill_mode_e;
endpackage

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned NUM_WB   = 2,
  parameter int unsigned WIDTH    = 4,
  localparam int unsigned RIDX_W  = $clog2(NUM_REGS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_WB-1:0]              set_vld_i,
  input  logic [NUM_WB-1:0][RIDX_W-1:0]  set_reg_i,
  input  logic [WIDTH-1:0]               clr_vld_i,
  input  logic [WIDTH-1:0][RIDX_W-1:0]   clr_reg_i,
  output logic [NUM_REGS-1:0]            avail_o
);
  logic [NUM_REGS-1:0] avail_q, avail_d;

  always_comb begin
    avail_d = avail_q;
    for (int p = 0; p < NUM_WB; p++)
      if (set_vld_i[p]) avail_d[set_reg_i[p]] = 1'b1;
    // issue clear is applied last so it wins
    for (int k = 0; k < WIDTH; k++)
      if (clr_vld_i[k]) avail_d[clr_reg_i[k]] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) avail_q <= '1;
    else         avail_q <= avail_d;
  end

  assign avail_o = avail_q;

  for (genvar k = 0; k < WIDTH; k++) begin : g_chk
    a_r5_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_vld_i[k] |=> !avail_o[$past(clr_reg_i[k])]);
  end
endmodule

// File: rtl/issue_select.sv
module issue_select #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned WIDTH    = 4,
  localparam int unsigned RIDX_W  = $clog2(NUM_REGS),
  localparam int unsigned CNT_W   = $clog2(WIDTH + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [WIDTH-1:0]              slot_vld_i,
  input  logic [WIDTH-1:0][RIDX_W-1:0]  slot_src1_i,
  input  logic [WIDTH-1:0][RIDX_W-1:0]  slot_src2_i,
  input  logic [WIDTH-1:0][RIDX_W-1:0]  slot_dst_i,
  input  logic [NUM_REGS-1:0]           avail_i,
  output logic [WIDTH-1:0]              issue_mask_o,
  output logic [CNT_W-1:0]              issue_cnt_o
);
  always_comb begin
    logic go, ok;
    go = 1'b1;
    issue_cnt_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      ok = slot_vld_i[i] && avail_i[slot_src1_i[i]] && avail_i[slot_src2_i[i]];
      for (int j = 0; j < i; j++)
        if (slot_dst_i[j] == slot_src1_i[i] || slot_dst_i[j] == slot_src2_i[i]) ok = 1'b0;
      go = go && ok;
      issue_mask_o[i] = go;
      if (go) issue_cnt_o = issue_cnt_o + 1'b1;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    a_r2_sources_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_mask_o[i] |-> (avail_i[slot_src1_i[i]] && avail_i[slot_src2_i[i]]));
    for (genvar j = 0; j < i; j++) begin : g_pair
      a_r4_no_raw_in_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_mask_o[i] |-> (slot_dst_i[j] != slot_src1_i[i] && slot_dst_i[j] != slot_src2_i[i]));
    end
  end
endmodule

// File: rtl/issue_window.sv
module issue_window #(
  parameter int unsigned WIDTH    = 4,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned NUM_WB   = 2,
  localparam int unsigned RIDX_W  = $clog2(NUM_REGS),
  localparam int unsigned CNT_W   = $clog2(WIDTH + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          glide_i,
  input  logic [WIDTH-1:0]              fetch_valid_i,
  input  logic [WIDTH-1:0][RIDX_W-1:0]  fetch_src1_i,
  input  logic [WIDTH-1:0][RIDX_W-1:0]  fetch_src2_i,
  input  logic [WIDTH-1:0][RIDX_W-1:0]  fetch_dst_i,
  output logic [WIDTH-1:0]              fetch_ready_o,
  input  logic [NUM_WB-1:0]             wb_valid_i,
  input  logic [NUM_WB-1:0][RIDX_W-1:0] wb_reg_i,
  output logic [WIDTH-1:0]              issue_valid_o,
  output logic [WIDTH-1:0][RIDX_W-1:0]  issue_src1_o,
  output logic [WIDTH-1:0][RIDX_W-1:0]  issue_src2_o,
  output logic [WIDTH-1:0][RIDX_W-1:0]  issue_dst_o
);
  import issue_pkg::*;

  refill_mode_e mode;
  logic [CNT_W-1:0] occ_q, occ_d, rem, acc, issue_cnt;
  logic [WIDTH-1:0][RIDX_W-1:0] q_s1, q_s2, q_d, n_s1, n_s2, n_d;
  logic [WIDTH-1:0] slot_vld, issue_mask;
  logic [NUM_REGS-1:0] avail;

  assign mode = refill_mode_e'(glide_i);

  always_comb
    for (int i = 0; i < WIDTH; i++) slot_vld[i] = (CNT_W'(i) < occ_q);

  issue_scoreboard #(.NUM_REGS(NUM_REGS), .NUM_WB(NUM_WB), .WIDTH(WIDTH)) u_sb (
    .clk_i, .rst_ni,
    .set_vld_i (wb_valid_i),
    .set_reg_i (wb_reg_i),
    .clr_vld_i (issue_mask),
    .clr_reg_i (q_d),
    .avail_o   (avail)
  );

  issue_select #(.NUM_REGS(NUM_REGS), .WIDTH(WIDTH)) u_sel (
    .clk_i, .rst_ni,
    .slot_vld_i   (slot_vld),
    .slot_src1_i  (q_s1),
    .slot_src2_i  (q_s2),
    .slot_dst_i   (q_d),
    .avail_i      (avail),
    .issue_mask_o (issue_mask),
    .issue_cnt_o  (issue_cnt)
  );

  assign rem = occ_q - issue_cnt;

  always_comb begin
    logic run;
    run = 1'b1;
    acc = '0;
    for (int k = 0; k < WIDTH; k++) begin
      if (mode == REFILL_GLIDE) fetch_ready_o[k] = (CNT_W'(k) < CNT_W'(WIDTH) - rem);
      else                      fetch_ready_o[k] = (occ_q == '0);
      run = run && fetch_valid_i[k] && fetch_ready_o[k];
      if (run) acc = acc + 1'b1;
    end
  end

  // compact survivors to slot 0, then append accepted fetch lanes
  always_comb begin
    int src, lane;
    n_s1 = q_s1;
    n_s2 = q_s2;
    n_d  = q_d;
    for (int i = 0; i < WIDTH; i++) begin
      src  = i + int'(issue_cnt);
      lane = i - int'(rem);
      if (CNT_W'(i) < rem && src < WIDTH) begin
        n_s1[i] = q_s1[src];
        n_s2[i] = q_s2[src];
        n_d[i]  = q_d[src];
      end else if (lane >= 0 && lane < int'(acc)) begin
        n_s1[i] = fetch_src1_i[lane];
        n_s2[i] = fetch_src2_i[lane];
        n_d[i]  = fetch_dst_i[lane];
      end
    end
    occ_d = rem + acc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
      q_s1  <= '0;
      q_s2  <= '0;
      q_d   <= '0;
    end else begin
      occ_q <= occ_d;
      q_s1  <= n_s1;
      q_s2  <= n_s2;
      q_d   <= n_d;
    end
  end

  assign issue_valid_o = issue_mask;
  assign issue_src1_o  = q_s1;
  assign issue_src2_o  = q_s2;
  assign issue_dst_o   = q_d;

  a_r6_aligned_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glide_i && occ_q != '0) |-> (fetch_ready_o == '0));
  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= CNT_W'(WIDTH));
  a_r3_issue_needs_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_cnt <= occ_q);
endmodule

// File: tb/sim_issue_window.sv
module sim_issue_window;
  localparam int W = 4, NR = 32, NWB = 2, RW = 5;

  logic clk_i = 0, rst_ni = 0, glide_i = 0;
  logic [W-1:0] fetch_valid_i = '0, fetch_ready_o, issue_valid_o;
  logic [W-1:0][RW-1:0] fetch_src1_i = '0, fetch_src2_i = '0, fetch_dst_i = '0;
  logic [W-1:0][RW-1:0] issue_src1_o, issue_src2_o, issue_dst_o;
  logic [NWB-1:0] wb_valid_i = '0;
  logic [NWB-1:0][RW-1:0] wb_reg_i = '0;

  int errors = 0, checks = 0;
  int m_occ = 0;
  int m_s1[W], m_s2[W], m_d[W];
  bit m_rdy[NR];
  int pend[NR];

  always #2.5 clk_i = ~clk_i;

  issue_window #(.WIDTH(W), .NUM_REGS(NR), .NUM_WB(NWB)) u0 (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_issue();
    int n = 0;
    for (int i = 0; i < m_occ; i++) begin
      bit ok = m_rdy[m_s1[i]] && m_rdy[m_s2[i]];
      for (int j = 0; j < i; j++)
        if (m_d[j] == m_s1[i] || m_d[j] == m_s2[i]) ok = 0;
      if (!ok) break;
      n++;
    end
    return n;
  endfunction

  task automatic step(string tag);
    int n, rem, acc;
    logic [W-1:0] e_vld, e_rdy;
    logic [W*RW*3-1:0] e_f, a_f;
    int t1[W], t2[W], td[W];
    #1;
    n = exp_issue();
    rem = m_occ - n;
    e_vld = '0; e_f = '0; a_f = '0;
    for (int k = 0; k < W; k++) begin
      e_vld[k] = (k < n);
      if (k < n) begin
        e_f[k*3*RW +: 3*RW] = {RW'(m_s1[k]), RW'(m_s2[k]), RW'(m_d[k])};
        a_f[k*3*RW +: 3*RW] = {issue_src1_o[k], issue_src2_o[k], issue_dst_o[k]};
      end
      e_rdy[k] = glide_i ? (k < W - rem) : (m_occ == 0);
    end
    check(tag, 64'(issue_valid_o), 64'(e_vld));
    check("R8", 64'(a_f), 64'(e_f));
    check(glide_i ? "R7" : "R6", 64'(fetch_ready_o), 64'(e_rdy));
    acc = 0;
    for (int k = 0; k < W; k++) begin
      if (!(fetch_valid_i[k] && e_rdy[k])) break;
      acc++;
    end
    for (int p = 0; p < NWB; p++)
      if (wb_valid_i[p]) begin
        m_rdy[wb_reg_i[p]] = 1;
        if (pend[wb_reg_i[p]] > 0) pend[wb_reg_i[p]]--;
      end
    for (int k = 0; k < n; k++) begin
      m_rdy[m_d[k]] = 0;
      pend[m_d[k]]++;
    end
    for (int i = 0; i < W; i++) begin
      t1[i] = m_s1[i]; t2[i] = m_s2[i]; td[i] = m_d[i];
    end
    for (int i = 0; i < rem; i++) begin
      m_s1[i] = t1[i+n]; m_s2[i] = t2[i+n]; m_d[i] = td[i+n];
    end
    for (int k = 0; k < acc; k++) begin
      m_s1[rem+k] = fetch_src1_i[k]; m_s2[rem+k] = fetch_src2_i[k]; m_d[rem+k] = fetch_dst_i[k];
    end
    m_occ = rem + acc;
    @(negedge clk_i);
  endtask

  task automatic put(int k, int s1, int s2, int d);
    fetch_valid_i[k] = 1;
    fetch_src1_i[k] = RW'(s1); fetch_src2_i[k] = RW'(s2); fetch_dst_i[k] = RW'(d);
  endtask

  task automatic idle();
    fetch_valid_i = '0; wb_valid_i = '0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < NR; r++) begin m_rdy[r] = 1; pend[r] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    #1;
    check("R1", 64'(issue_valid_o), 64'(0));
    check("R1", 64'(fetch_ready_o), 64'({W{1'b1}}));
    glide_i = 1;
    #1;
    check("R1", 64'(fetch_ready_o), 64'({W{1'b1}}));
    glide_i = 0;
    @(negedge clk_i);
    // aligned group: slot1 reads slot0's dst, slot2/3 independent
    put(0, 2, 3, 1); put(1, 1, 5, 4); put(2, 7, 7, 6); put(3, 9, 9, 8);
    step("R9");
    idle();
    step("R4 R3");          // only slot0 issues
    step("R2");             // r1 still pending
    wb_valid_i[0] = 1; wb_reg_i[0] = 5'd1;
    step("R2");             // writeback not yet visible
    idle();
    step("R3");             // remaining three issue together
    step("R6");             // empty again
    // clear beats set on same register
    glide_i = 1;
    put(0, 11, 11, 10);
    step("R7");
    idle();
    wb_valid_i[0] = 1; wb_reg_i[0] = 5'd10;
    step("R5");
    idle();
    put(0, 10, 10, 12);
    step("R9");
    idle();
    step("R5");             // reader of r10 stays blocked
    // random phase, small register set for dense hazards
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc % 53 == 0) glide_i = $urandom_range(0, 1);
      for (int k = 0; k < W; k++)
        if ($urandom_range(0, 3) != 0)
          put(k, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
        else fetch_valid_i[k] = 0;
      for (int p = 0; p < NWB; p++) begin
        int st = $urandom_range(0, NR - 1);
        wb_valid_i[p] = 0;
        if ($urandom_range(0, 2) != 0)
          for (int r = 0; r < NR; r++)
            if (pend[(st + r) % NR] > 0) begin
              wb_valid_i[p] = 1; wb_reg_i[p] = RW'((st + r) % NR);
              break;
            end
      end
      step("R3 R4 R2");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule